// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small set of recently used page mappings. Each entry stores the virtual page number as its tag and a cached page table entry as its value: the physical frame number plus read, write and execute permission bits. A lookup compares the requested page number against every entry at once. In the same cycle it reports hit or miss, the frame number, and whether the requested kind of access is forbidden. When the access is allowed, it also gives the physical address, formed by joining the frame number to the 12-bit page offset.

The surrounding memory unit uses the block as follows. After a miss it walks the page tables and installs the result through the fill port. On a process switch it drops every mapping with a flush. When the protection of one page changes, it drops that single mapping with an invalidate. When a fill finds no free slot, the block evicts an entry using a use-bit policy, so that recently referenced mappings tend to stay.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports hit=0, viol=0, frame 0 and physical address 0.
- R2: A lookup is combinational on the stored state. A page filled in one cycle hits from the next cycle on. In the cycle of the hit, the outputs give the stored frame number and the physical address {frame, offset}, with the 12-bit offset in the low bits.
- R3: The access code is 0 for read, 1 for write, 2 for execute and 3 for reserved. The fill permission field has bit 0 for read, bit 1 for write and bit 2 for execute. A hit whose permission bit for the requested access is clear raises viol together with hit. The reserved code always raises viol on a hit.
- R4: The physical address is 0 unless hit=1 and viol=0. The frame output is 0 on a miss. A lookup with the request input low reports a miss.
- R5: A flush makes every entry invalid from the next cycle on. A flush overrides an invalidate or a fill given in the same cycle, and that fill is lost.
- R6: An invalidate removes only the mapping of the named page, and all other mappings stay. A fill given in the same cycle as an invalidate is ignored.
- R7: A fill whose page number is already present overwrites that entry's frame and permissions in place, so exactly one entry matches afterwards.
- R8: A fill of a new page goes into the lowest-indexed invalid entry when one exists, so no valid mapping is evicted while a free entry remains.
- R9: Each entry has a use bit. It is set by a lookup hit, including a hit that raises viol, and by a fill into that entry. A fill into a full cache evicts the lowest-indexed entry whose use bit is clear. When an update would leave every use bit set, all use bits are cleared except the one for the entry just filled, or for the entry just hit if no fill took place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_off | input | 12 | Page offset of the access |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | A valid entry matches the lookup page |
| lk_viol | output | 1 | Hit, but the access is not permitted |
| lk_ppn | output | PPN_W | Frame number of the matching entry, 0 on a miss |
| lk_paddr | output | PPN_W+12 | Physical address, 0 unless the translation is usable |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Page number to install |
| fill_ppn | input | PPN_W | Frame number to install |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| flush_all | input | 1 | Invalidate every entry |
| inval_en | input | 1 | Invalidate one page |
| inval_vpn | input | 20 | Page number to invalidate |

## Verification
The hardest state to reach is the saturation of the use bits. Every entry must be valid, and one last fill or hit must be the event that would set the final bit, which triggers the collective clear. Only after that does the choice of victim among entries with a clear use bit become visible, through which page later misses. A directed sequence fills the whole cache with no lookups, checks which pages survive two further fills, and then opens one slot with an invalidate to show that a free entry is taken before any eviction. A long random phase then draws from a page pool only slightly larger than the capacity. This keeps the cache near full, so saturation, overwrites and evictions recur while the bench model tracks every mapping.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VPN_W = 20;
    localparam int OFF_W = 12;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    function automatic logic perm_allows(input perm_t p, input acc_e a);
        case (a)
            ACC_RD:  return p.r;
            ACC_WR:  return p.w;
            ACC_EX:  return p.x;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [VPN_W-1:0] tags [N],
    input  logic [N-1:0]     valid,
    input  logic [VPN_W-1:0] key,
    output logic [N-1:0]     oh,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    for (genvar e = 0; e < N; e++) begin : g_cmp
        assign oh[e] = valid[e] && (tags[e] == key);
    end

    tlb_prio #(.N(N), .IDX_W(IDX_W)) enc_i (
        .vec(oh), .any(hit), .idx(idx)
    );
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     used,
    output logic [IDX_W-1:0] victim
);
    logic             free_any, stale_any;
    logic [IDX_W-1:0] free_idx, stale_idx;

    tlb_prio #(.N(N), .IDX_W(IDX_W)) free_i (
        .vec(~valid), .any(free_any), .idx(free_idx)
    );
    tlb_prio #(.N(N), .IDX_W(IDX_W)) stale_i (
        .vec(~used), .any(stale_any), .idx(stale_idx)
    );

    assign victim = free_any ? free_idx : stale_idx;

    AST_VICTIM_EXISTS: assert property (@(posedge clk) disable iff (rst)
        free_any || stale_any); // R9
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache import tlb_pkg::*; #(
    parameter int N_ENT = 16,
    parameter int PPN_W = 20,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int PA_W  = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFF_W-1:0] lk_off,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic             lk_viol,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [2:0]       fill_perm,
    input  logic             flush_all,
    input  logic             inval_en,
    input  logic [VPN_W-1:0] inval_vpn
);
    localparam int N_PORT = 3; // 0 lookup, 1 fill, 2 invalidate

    logic [VPN_W-1:0] tag_q  [N_ENT];
    logic [PPN_W-1:0] ppn_q  [N_ENT];
    perm_t            perm_q [N_ENT];
    logic [N_ENT-1:0] valid_q, use_q;
    logic [N_ENT-1:0] valid_n, use_n, keep;

    logic [VPN_W-1:0] keys  [N_PORT];
    logic [N_ENT-1:0] m_oh  [N_PORT];
    logic             m_hit [N_PORT];
    logic [IDX_W-1:0] m_idx [N_PORT];

    assign keys[0] = lk_vpn;
    assign keys[1] = fill_vpn;
    assign keys[2] = inval_vpn;

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        tlb_match #(.N(N_ENT), .IDX_W(IDX_W)) match_i (
            .tags(tag_q), .valid(valid_q), .key(keys[p]),
            .oh(m_oh[p]), .hit(m_hit[p]), .idx(m_idx[p])
        );
        AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (rst)
            $onehot0(m_oh[p])); // R7
    end

    logic [IDX_W-1:0] victim, wr_idx, sel;
    logic             wr_en, acc_ok;

    tlb_repl #(.N(N_ENT), .IDX_W(IDX_W)) repl_i (
        .clk(clk), .rst(rst), .valid(valid_q), .used(use_q), .victim(victim)
    );

    // lookup side: single cycle, combinational on the stored state
    assign sel      = m_idx[0];
    assign lk_hit   = lk_req && m_hit[0];
    assign acc_ok   = perm_allows(perm_q[sel], acc_e'(lk_acc));
    assign lk_viol  = lk_hit && !acc_ok;
    assign lk_ppn   = lk_hit ? ppn_q[sel] : '0;
    assign lk_paddr = (lk_hit && acc_ok) ? {ppn_q[sel], lk_off} : '0;

    // update side: flush > invalidate > fill
    assign wr_idx = m_hit[1] ? m_idx[1] : victim;

    always_comb begin
        valid_n = valid_q;
        use_n   = use_q;
        keep    = '0;
        wr_en   = 1'b0;
        if (lk_hit) begin
            use_n[sel] = 1'b1;
            keep[sel]  = 1'b1;
        end
        if (inval_en) begin
            if (m_hit[2]) begin
                valid_n[m_idx[2]] = 1'b0;
                use_n[m_idx[2]]   = 1'b0;
            end
        end else if (fill_en) begin
            wr_en           = 1'b1;
            valid_n[wr_idx] = 1'b1;
            use_n[wr_idx]   = 1'b1;
            keep            = '0;
            keep[wr_idx]    = 1'b1;
        end
        if (&use_n) use_n = keep;
        if (flush_all) begin
            valid_n = '0;
            use_n   = '0;
            wr_en   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            use_q   <= '0;
        end else begin
            valid_q <= valid_n;
            use_q   <= use_n;
        end
        if (!rst && wr_en) begin
            tag_q[wr_idx]  <= fill_vpn;
            ppn_q[wr_idx]  <= fill_ppn;
            perm_q[wr_idx] <= perm_t'(fill_perm);
        end
    end

    function automatic logic tag_live(input logic [VPN_W-1:0] k);
        tag_live = 1'b0;
        for (int e = 0; e < N_ENT; e++) begin
            if (valid_q[e] && tag_q[e] == k) tag_live = 1'b1;
        end
    endfunction

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_q == '0)); // R5
    AST_INVAL_GONE: assert property (@(posedge clk) disable iff (rst)
        (inval_en && !flush_all) |=> !tag_live($past(inval_vpn))); // R6
    AST_FILL_LIVE: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !inval_en && !flush_all) |=> tag_live($past(fill_vpn))); // R7
    AST_USE_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        !(&use_q)); // R9
    AST_VIOL_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        lk_viol |-> (lk_hit && lk_paddr == '0)); // R3
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int PW = 20;

    logic        clk = 1'b0, rst = 1'b1;
    logic        lk_req, lk_hit, lk_viol;
    logic [19:0] lk_vpn;
    logic [11:0] lk_off;
    logic [1:0]  lk_acc;
    logic [PW-1:0] lk_ppn;
    logic [PW+11:0] lk_paddr;
    logic        fill_en, flush_all, inval_en;
    logic [19:0] fill_vpn, inval_vpn;
    logic [PW-1:0] fill_ppn;
    logic [2:0]  fill_perm;

    int tests = 0, fails = 0;

    xlat_cache #(.N_ENT(N), .PPN_W(PW)) dut_i (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_viol(lk_viol), .lk_ppn(lk_ppn),
        .lk_paddr(lk_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm), .flush_all(flush_all),
        .inval_en(inval_en), .inval_vpn(inval_vpn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model built from the requirements
    bit          m_v [N];
    bit          m_u [N];
    logic [19:0] m_tag [N];
    logic [PW-1:0] m_ppn [N];
    logic [2:0]  m_perm [N];

    function automatic int m_find(input logic [19:0] k);
        for (int e = 0; e < N; e++) if (m_v[e] && m_tag[e] == k) return e;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic probe(input string req);
        int h;
        bit eh, ev;
        logic [PW-1:0] ep;
        logic [PW+11:0] ea;
        #1;
        h  = lk_req ? m_find(lk_vpn) : -1;
        eh = (h >= 0);
        ev = 1'b0; ep = '0; ea = '0;
        if (eh) begin
            ep = m_ppn[h];
            case (lk_acc)
                2'd0: ev = !m_perm[h][0];
                2'd1: ev = !m_perm[h][1];
                2'd2: ev = !m_perm[h][2];
                default: ev = 1'b1;
            endcase
            if (!ev) ea = {m_ppn[h], lk_off};
        end
        chk({lk_hit, lk_viol, lk_ppn, lk_paddr} === {eh, ev, ep, ea}, req,
            {lk_hit, lk_viol, lk_ppn, lk_paddr}, {eh, ev, ep, ea});
    endtask

    task automatic idle();
        lk_req = 0; lk_vpn = '0; lk_off = '0; lk_acc = '0;
        fill_en = 0; fill_vpn = '0; fill_ppn = '0; fill_perm = '0;
        flush_all = 0; inval_en = 0; inval_vpn = '0;
    endtask

    task automatic model_update();
        int h, j, t, keep;
        bit all;
        h = lk_req ? m_find(lk_vpn) : -1;
        j = m_find(inval_vpn);
        t = m_find(fill_vpn);
        if (t < 0) begin
            for (int e = N - 1; e >= 0; e--) if (!m_v[e]) t = e;
        end
        if (t < 0) begin
            for (int e = N - 1; e >= 0; e--) if (!m_u[e]) t = e;
        end
        keep = -1;
        if (h >= 0) begin m_u[h] = 1; keep = h; end
        if (inval_en) begin
            if (j >= 0) begin m_v[j] = 0; m_u[j] = 0; end
        end else if (fill_en) begin
            m_v[t] = 1; m_u[t] = 1; keep = t;
            m_tag[t] = fill_vpn; m_ppn[t] = fill_ppn; m_perm[t] = fill_perm;
        end
        all = 1;
        for (int e = 0; e < N; e++) if (!m_u[e]) all = 0;
        if (all) for (int e = 0; e < N; e++) m_u[e] = (e == keep);
        if (flush_all) for (int e = 0; e < N; e++) begin m_v[e] = 0; m_u[e] = 0; end
    endtask

    task automatic adv();
        @(posedge clk);
        if (!rst) model_update();
        @(negedge clk);
        idle();
    endtask

    task automatic look(input logic [19:0] v, input logic [1:0] a, input logic [11:0] o);
        lk_req = 1; lk_vpn = v; lk_acc = a; lk_off = o;
    endtask

    task automatic fill(input logic [19:0] v, input logic [PW-1:0] p, input logic [2:0] pm);
        fill_en = 1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd5077));
        idle();
        for (int e = 0; e < N; e++) begin m_v[e] = 0; m_u[e] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: empty after reset
        look(20'h00005, 2'd0, 12'h123); probe("R1");
        chk(lk_hit == 0 && lk_paddr == 0, "R1", {lk_hit, lk_paddr}, 0);
        adv();

        // R2: fill then hit next cycle
        fill(20'h12345, 20'hABCDE, 3'b001); adv();
        look(20'h12345, 2'd0, 12'h678); probe("R2");
        chk(lk_paddr == 32'hABCDE678 && lk_ppn == 20'hABCDE, "R2", lk_paddr, 32'hABCDE678);
        adv();
        // R3/R4: write to read-only page, reserved access
        look(20'h12345, 2'd1, 12'h678); probe("R3");
        chk(lk_hit && lk_viol && lk_paddr == 0, "R4", {lk_hit, lk_viol, lk_paddr}, {2'b11, 32'h0});
        adv();
        look(20'h12345, 2'd3, 12'h001); probe("R3");
        chk(lk_viol == 1, "R3", lk_viol, 1);
        adv();
        look(20'h12345, 2'd0, 12'h001); lk_req = 0; probe("R4");
        chk(lk_hit == 0 && lk_ppn == 0, "R4", {lk_hit, lk_ppn}, 0);
        adv();
        // R7: overwrite in place
        fill(20'h12345, 20'h11111, 3'b111); adv();
        look(20'h12345, 2'd2, 12'hFFF); probe("R7");
        chk(lk_paddr == 32'h11111FFF && !lk_viol, "R7", lk_paddr, 32'h11111FFF);
        adv();
        // R6: invalidate with a same-cycle fill
        fill(20'h00777, 20'h00777, 3'b111); adv();
        inval_en = 1; inval_vpn = 20'h12345; fill(20'h22222, 20'h3, 3'b111); adv();
        look(20'h12345, 2'd0, 0); probe("R6");
        chk(lk_hit == 0, "R6", lk_hit, 0); adv();
        look(20'h22222, 2'd0, 0); probe("R6");
        chk(lk_hit == 0, "R6", lk_hit, 0); adv();
        look(20'h00777, 2'd0, 0); probe("R6");
        chk(lk_hit == 1, "R6", lk_hit, 1); adv();
        // R5: flush with a same-cycle fill
        flush_all = 1; fill(20'h33333, 20'h4, 3'b111); adv();
        look(20'h00777, 2'd0, 0); probe("R5");
        chk(lk_hit == 0, "R5", lk_hit, 0); adv();
        look(20'h33333, 2'd0, 0); probe("R5");
        chk(lk_hit == 0, "R5", lk_hit, 0); adv();

        // R9: saturate, then evict by use bits
        for (int i = 0; i < N; i++) begin
            fill(20'h100 + 20'(i), 20'h500 + 20'(i), 3'b111); probe("R9"); adv();
        end
        look(20'h103, 2'd0, 0); probe("R9"); adv();
        fill(20'h200, 20'h9, 3'b001); probe("R9"); adv();
        look(20'h100, 2'd0, 0); probe("R9");
        chk(lk_hit == 0, "R9", lk_hit, 0); adv();
        look(20'h200, 2'd0, 0); probe("R9");
        chk(lk_hit == 1, "R9", lk_hit, 1); adv();
        fill(20'h201, 20'hA, 3'b001); probe("R9"); adv();
        look(20'h101, 2'd0, 0); probe("R9");
        chk(lk_hit == 0, "R9", lk_hit, 0); adv();
        look(20'h103, 2'd0, 0); probe("R9");
        chk(lk_hit == 1, "R9", lk_hit, 1); adv();
        // R8: free slot taken before any eviction
        inval_en = 1; inval_vpn = 20'h105; adv();
        fill(20'h300, 20'hB, 3'b001); adv();
        for (int i = 2; i < N; i++) begin
            if (i != 5) begin
                look(20'h100 + 20'(i), 2'd0, 0); probe("R8");
                chk(lk_hit == 1, "R8", lk_hit, 1); adv();
            end
        end
        look(20'h300, 2'd0, 0); probe("R8");
        chk(lk_hit == 1, "R8", lk_hit, 1); adv();

        // random phase: R2 R3 R5 R6 R7 R9 against the model
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = $urandom_range(99);
            lk_req = ($urandom_range(9) < 8);
            lk_vpn = 20'($urandom_range(23)); lk_acc = 2'($urandom_range(3));
            lk_off = 12'($urandom);
            if (r < 40) fill(20'($urandom_range(23)), 20'($urandom), 3'($urandom));
            if ($urandom_range(99) < 5) begin inval_en = 1; inval_vpn = 20'($urandom_range(23)); end
            if ($urandom_range(199) < 2) flush_all = 1;
            probe("R2 random");
            adv();
        end
        summary();
    end
endmodule